// File: doc/BRIEF.md
# Sixty-four-bit ALU with Registered Status Flags

This block is the arithmetic core of a simple scalar datapath. Two 64-bit operands, a 6-bit operation code and a 5-bit shift count enter. A 64-bit result leaves in the same cycle, through combinational logic only. Each operation that is decoded and marked valid also loads a five-bit status register on the next rising clock edge. That register holds the parity, zero, sign, auxiliary carry and carry of the result.

The block does the eight core operations: add, subtract, AND, OR, XOR, invert, multiply (low half) and set-less-than. It also does set-greater-than, two logical shifts and two rotates. Immediate forms need no separate path, because the decode stage puts a sign-extended constant on operand B. Operand fetch, register-file access and division belong to other blocks.

Top module: `flagged_alu`

## Requirements
- R1: Opcode 000000 gives result = A + B modulo 2^64. The carry flag is the carry out of bit 63. The auxiliary flag is the carry out of bit 3 into bit 4.
- R2: Opcode 000001 gives result = A - B modulo 2^64. The carry flag is 1 when a borrow enters bit 63, which happens when A < B unsigned. The auxiliary flag is 1 when the low four bits borrow, which happens when A[3:0] < B[3:0].
- R3: Opcode 000010 gives A AND B. Opcode 000011 gives A OR B. Opcode 000110 gives A XOR B. Opcode 000111 gives the bitwise inverse of A, and operand B has no effect on it.
- R4: Opcode 000100 gives 1 when A < B as signed numbers. Opcode 100000 gives 1 when A > B as signed numbers. Both give 0 otherwise, and bits 63..1 of the result are always 0.
- R5: Opcode 000101 gives the low 64 bits of the product A * B.
- R6: The shift and rotate operations move operand A by the 5-bit count, from 0 to 31. Opcode 011000 is a logical shift left. Opcode 011001 is a logical shift right. Opcode 011010 rotates left. Opcode 011011 rotates right.
- R7: The flag output holds parity in bit 0, zero in bit 1, sign in bit 2, auxiliary carry in bit 3 and carry in bit 4. Parity is 1 when the result has an even number of 1 bits. Zero is 1 when the result is 0. Sign is result bit 63. The flags take these values at the rising edge that samples a valid, decoded operation.
- R8: Every operation other than add and subtract loads 0 into the carry and auxiliary carry flags.
- R9: While the valid input is low, the flags keep their value.
- R10: Any other opcode drives a result of 0 and leaves the flags unchanged, even when the valid input is high.
- R11: An active-low asynchronous reset clears all five flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation valid; permits a flag update |
| op_code | input | 6 | Operation select |
| opnd_a | input | 64 | First operand |
| opnd_b | input | 64 | Second operand, or a sign-extended immediate |
| shamt | input | 5 | Shift or rotate count |
| result | output | 64 | Combinational result |
| flags | output | 5 | {carry, aux carry, sign, zero, parity} |

## Verification
The only state in the block is the five-bit flag register. A fault in it, such as a missed load, a load when none is allowed, or a flag in the wrong position, appears on the flags port at the first sampling edge after the operation that exposes it. A fault in the datapath appears on the result port in the same cycle. Every opcode, including an undecoded one, is swept over a grid of edge-case operand pairs. The grid includes operands that cross the nibble boundary, the sign boundary and the carry boundary, so each flag bit is seen both set and clear. Every flag vector is compared with the flags expected from the last operation that should have loaded them.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int OP_W = 6;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 6'b000000,
        OP_SUB = 6'b000001,
        OP_AND = 6'b000010,
        OP_OR  = 6'b000011,
        OP_SLT = 6'b000100,
        OP_MUL = 6'b000101,
        OP_XOR = 6'b000110,
        OP_INV = 6'b000111,
        OP_SHL = 6'b011000,
        OP_SHR = 6'b011001,
        OP_ROL = 6'b011010,
        OP_ROR = 6'b011011,
        OP_SGT = 6'b100000
    } alu_op_e;

    // Field order sets the bit position: the first field is bit 4.
    typedef struct packed {
        logic carry;
        logic aux;
        logic sign;
        logic zero;
        logic parity;
    } alu_flags_t;

    typedef struct packed {
        alu_flags_t flags;
    } alu_state_t;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int W   = 64,
    parameter int NIB = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         carry,
    output logic         aux
);
    logic [W:0]   full;
    logic [NIB:0] low;

    always_comb begin
        if (sub) begin
            full = {1'b0, a} - {1'b0, b};
            low  = {1'b0, a[NIB-1:0]} - {1'b0, b[NIB-1:0]};
        end else begin
            full = {1'b0, a} + {1'b0, b};
            low  = {1'b0, a[NIB-1:0]} + {1'b0, b[NIB-1:0]};
        end
    end

    assign sum   = full[W-1:0];
    assign carry = full[W];
    assign aux   = low[NIB];
endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
    parameter int W  = 64,
    parameter int SW = 5
) (
    input  logic [W-1:0]  a,
    input  logic [SW-1:0] amt,
    input  logic [1:0]    mode,
    output logic [W-1:0]  y
);
    localparam int CW = $clog2(W) + 1;

    logic [CW-1:0] back;
    assign back = CW'(W) - CW'(amt);

    always_comb begin
        case (mode)
            2'd0:    y = a << amt;
            2'd1:    y = a >> amt;
            2'd2:    y = (a << amt) | (a >> back);
            default: y = (a >> amt) | (a << back);
        endcase
    end
endmodule

// File: rtl/flagged_alu.sv
module flagged_alu
    import alu_pkg::*;
#(
    parameter int W   = 64,
    parameter int SW  = 5,
    parameter int NIB = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [OP_W-1:0] op_code,
    input  logic [W-1:0]    opnd_a,
    input  logic [W-1:0]    opnd_b,
    input  logic [SW-1:0]   shamt,
    output logic [W-1:0]    result,
    output logic [4:0]      flags
);
    alu_state_t st_d, st_q;

    logic [W-1:0] as_sum, sh_y, prod;
    logic         as_carry, as_aux, is_sub, known, arith;

    assign is_sub = (op_code == OP_SUB);
    assign prod   = opnd_a * opnd_b;

    alu_addsub #(.W(W), .NIB(NIB)) u_addsub (
        .a(opnd_a), .b(opnd_b), .sub(is_sub),
        .sum(as_sum), .carry(as_carry), .aux(as_aux)
    );

    alu_shift #(.W(W), .SW(SW)) u_shift (
        .a(opnd_a), .amt(shamt), .mode(op_code[1:0]), .y(sh_y)
    );

    always_comb begin
        result = '0;
        known  = 1'b1;
        arith  = 1'b0;
        case (op_code)
            OP_ADD, OP_SUB: begin result = as_sum; arith = 1'b1; end
            OP_AND: result = opnd_a & opnd_b;
            OP_OR:  result = opnd_a | opnd_b;
            OP_XOR: result = opnd_a ^ opnd_b;
            OP_INV: result = ~opnd_a;
            OP_MUL: result = prod;
            OP_SLT: result = W'($signed(opnd_a) < $signed(opnd_b));
            OP_SGT: result = W'($signed(opnd_a) > $signed(opnd_b));
            OP_SHL, OP_SHR, OP_ROL, OP_ROR: result = sh_y;
            default: known = 1'b0;
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (in_valid && known) begin
            st_d.flags.carry  = arith & as_carry;
            st_d.flags.aux    = arith & as_aux;
            st_d.flags.sign   = result[W-1];
            st_d.flags.zero   = (result == '0);
            st_d.flags.parity = ~^result;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags = st_q.flags;

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(flags)); // R9
    AST_UNKNOWN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !known) |=> $stable(flags)); // R10
    AST_UNKNOWN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !known |-> (result == '0)); // R10
    AST_ZERO_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && known) |=> (flags[1] == ($past(result) == '0))); // R7
    AST_PARITY_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && known) |=> (flags[0] == ~^$past(result))); // R7
    AST_NO_CARRY_LOGIC: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && known && !arith) |=> (flags[4:3] == 2'b00)); // R8
    AST_CMP_BOOL: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == OP_SLT || op_code == OP_SGT) |-> (result[W-1:1] == '0)); // R4
    AST_SUB_BORROW: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_sub) |=> (flags[4] == ($past(opnd_a) < $past(opnd_b)))); // R2
endmodule

// File: tb/flagged_alu_bench.sv
module flagged_alu_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [5:0]  op_code = '0;
    logic [63:0] opnd_a = '0, opnd_b = '0;
    logic [4:0]  shamt = '0;
    logic [63:0] result;
    logic [4:0]  flags;

    int checks = 0;
    int failures = 0;
    logic [4:0] exp_flags = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flagged_alu u_flagged_alu (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .shamt(shamt),
        .result(result), .flags(flags)
    );

    function automatic logic [63:0] pat(int i);
        case (i)
            0: return 64'h0;
            1: return 64'h1;
            2: return 64'hFFFF_FFFF_FFFF_FFFF;
            3: return 64'h8000_0000_0000_0000;
            4: return 64'h7FFF_FFFF_FFFF_FFFF;
            5: return 64'h0F0F_0F0F_0F0F_0F0F;
            6: return 64'h1234_5678_9ABC_DEF0;
            default: return 64'hFFFF_FFFF_0000_000F;
        endcase
    endfunction

    function automatic logic [5:0] opsel(int k);
        case (k)
            0: return 6'b000000;  1: return 6'b000001;
            2: return 6'b000010;  3: return 6'b000011;
            4: return 6'b000100;  5: return 6'b000101;
            6: return 6'b000110;  7: return 6'b000111;
            8: return 6'b011000;  9: return 6'b011001;
            10: return 6'b011010; 11: return 6'b011011;
            12: return 6'b100000;
            default: return 6'b111111;
        endcase
    endfunction

    function automatic string tag(logic [5:0] op);
        case (op)
            6'b000000: return "R1";
            6'b000001: return "R2";
            6'b000010, 6'b000011, 6'b000110, 6'b000111: return "R3";
            6'b000100, 6'b100000: return "R4";
            6'b000101: return "R5";
            6'b011000, 6'b011001, 6'b011010, 6'b011011: return "R6";
            default: return "R10";
        endcase
    endfunction

    task automatic check(string req, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic reference(input logic [5:0] op, input logic [63:0] a,
                             input logic [63:0] b, input logic [4:0] sh,
                             output logic [63:0] r, output logic ok,
                             output logic c, output logic ac);
        r = '0; ok = 1'b1; c = 1'b0; ac = 1'b0;
        case (op)
            6'b000000: begin
                r = a + b; c = (r < a);
                ac = (int'(a[3:0]) + int'(b[3:0])) > 15;
            end
            6'b000001: begin r = a - b; c = (a < b); ac = (a[3:0] < b[3:0]); end
            6'b000010: r = a & b;
            6'b000011: r = a | b;
            6'b000110: r = a ^ b;
            6'b000111: r = ~a;
            6'b000101: r = a * b;
            6'b000100: r = {63'b0, $signed(a) < $signed(b)};
            6'b100000: r = {63'b0, $signed(a) > $signed(b)};
            6'b011000: r = a << sh;
            6'b011001: r = a >> sh;
            6'b011010: begin r = a; for (int k = 0; k < int'(sh); k++) r = {r[62:0], r[63]}; end
            6'b011011: begin r = a; for (int k = 0; k < int'(sh); k++) r = {r[0], r[63:1]}; end
            default: ok = 1'b0;
        endcase
    endtask

    // Drive at a falling edge, check the result 1 time unit later,
    // then check the flags at the next falling edge (after one rising edge).
    task automatic apply(logic v, logic [5:0] op, logic [63:0] a, logic [63:0] b, logic [4:0] sh);
        logic [63:0] r;
        logic ok, c, ac;
        reference(op, a, b, sh, r, ok, c, ac);
        op_code = op; opnd_a = a; opnd_b = b; shamt = sh; in_valid = v;
        #1;
        check(tag(op), result, r);
        if (v && ok) exp_flags = {c, ac, r[63], r == 64'h0, ~^r};
        @(negedge clk);
        check(v ? (ok ? "R7/R8" : "R10") : "R9", {59'b0, flags}, {59'b0, exp_flags});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        check("R11", {59'b0, flags}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11", {59'b0, flags}, 64'h0);

        for (int k = 0; k < 14; k++)
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++)
                    apply(1'b1, opsel(k), pat(i), pat(j), 5'((i * 7 + j * 3) % 32));

        // R6: full count sweep for shifts and rotates
        for (int k = 8; k < 12; k++)
            for (int s = 0; s < 32; s++)
                apply(1'b1, opsel(k), 64'h8123_4567_89AB_CDEF, 64'h0, 5'(s));

        // R1/R2: auxiliary boundary and carry/borrow boundary
        apply(1'b1, 6'b000000, 64'h0000_0000_0000_0008, 64'h0000_0000_0000_0008, 5'd0);
        apply(1'b1, 6'b000001, 64'h0000_0000_0000_0010, 64'h0000_0000_0000_0001, 5'd0);
        apply(1'b1, 6'b000000, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 5'd0);

        // R9: valid low leaves a set carry/aux pattern untouched
        apply(1'b0, 6'b000010, 64'h0, 64'h0, 5'd0);
        apply(1'b0, 6'b000000, 64'h5, 64'h7, 5'd0);
        // R10: undecoded opcode with valid high
        apply(1'b1, 6'b101010, 64'h0, 64'h0, 5'd0);

        // R11: reset in mid-run clears flags
        rst_n = 1'b0;
        #1;
        check("R11", {59'b0, flags}, 64'h0);
        exp_flags = '0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11", {59'b0, flags}, 64'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule